// File: doc/BRIEF.md
# Pipeline Bypass and Load-Use Interlock

This block watches the operands of the instruction in the execute stage of a five-stage, in-order integer pipeline. It compares their source register numbers with the destination numbers of the two older instructions still in flight. It produces three select codes: one for each ALU operand and one for the store-data path. Each code tells the datapath multiplexer whether to take the register-file value, the ALU result held after execute, or the write-back value held after the memory stage. The supported instructions are add and subtract (register-register), word load and word store.

A loaded word exists only at the end of the memory stage, so a consumer right behind a load cannot be served by a bypass. For this case the block raises a one-cycle stall. The pipeline control uses it to freeze fetch and decode and to set the nop bit of the execute-stage register, which inserts a bubble. Once the bubble has passed, the loaded value is bypassed from the write-back register. The selects and the stall are purely combinational. The clock and the active-low reset only time the embedded checks.

Conditional-branch operands are never examined. Instruction scheduling guarantees that a branch never depends on either of the two instructions ahead of it.

Top module: `hz_unit`

## Requirements
- R1: Select codes are 0 = register file, 1 = ALU result after execute (EX/MEM), 2 = write-back data (MEM/WB). The operand-A select is 1 when the EX/MEM producer is valid (nop bit 0), writes a register (write enable 1), is not a load, has a non-zero destination, and that destination equals the execute-stage rs.
- R2: When both the EX/MEM and MEM/WB producers qualify for the same source register, the select is 1. The younger producer wins.
- R3: When only the MEM/WB producer (nop 0, write enable 1, destination non-zero) matches the source register, the select is 2.
- R4: A producer whose nop bit is 1, whose write enable is 0, or whose destination is register 0 causes neither a bypass nor a stall. The select is 0 when no producer qualifies.
- R5: The operand-B select applies the R1 to R3 rules to the execute-stage rt when that instruction is register-register (I-type flag 0). It is 0 when the I-type flag is 1, because an immediate is used.
- R6: The store-data select applies the R1 to R3 rules to rt when the execute-stage memory-write flag is 1, and is 0 otherwise.
- R7: When the execute-stage nop bit is 1, all three selects are 0 and the stall is 0.
- R8: The stall is 1 when the execute-stage instruction is a valid load (memory-read flag 1, write enable 1, destination non-zero) whose destination equals the decode-stage rs, and the decode stage is not a nop.
- R9: A match on the decode-stage rt raises the stall only when the decode-stage rt-read flag is 1, meaning the instruction is register-register or a store. A load does not read rt.
- R10: A load in the EX/MEM register (memory-read flag 1) is never a source for select code 1. The select falls back to the MEM/WB rule or to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded checks |
| rst_n | input | 1 | Active-low reset for the embedded checks |
| id_nop | input | 1 | Decode stage holds a bubble |
| id_rs | input | AW | Decode-stage rs number |
| id_rt | input | AW | Decode-stage rt number |
| id_uses_rt | input | 1 | Decode-stage instruction reads rt |
| ex_nop | input | 1 | Execute stage holds a bubble |
| ex_rs | input | AW | Execute-stage rs number |
| ex_rt | input | AW | Execute-stage rt number |
| ex_dst | input | AW | Execute-stage destination number |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_is_itype | input | 1 | Execute-stage instruction uses an immediate |
| ex_rd_mem | input | 1 | Execute-stage instruction is a load |
| ex_wr_mem | input | 1 | Execute-stage instruction is a store |
| mem_nop | input | 1 | EX/MEM register holds a bubble |
| mem_dst | input | AW | EX/MEM destination number |
| mem_wen | input | 1 | EX/MEM write enable |
| mem_rd_mem | input | 1 | EX/MEM instruction is a load |
| wb_nop | input | 1 | MEM/WB register holds a bubble |
| wb_dst | input | AW | MEM/WB destination number |
| wb_wen | input | 1 | MEM/WB write enable |
| sel_a | output | 2 | Operand-A bypass select |
| sel_b | output | 2 | Operand-B bypass select |
| sel_st | output | 2 | Store-data bypass select |
| stall | output | 1 | Load-use interlock request |

## Verification
The checks assume that the decode flags of each stage are consistent with a single instruction kind. A store is I-type and writes no register, a load is I-type with write enable set, and register-register operations clear both memory flags. They also assume that the clock only samples inputs after they have settled. The bench builds every stage from one of four instruction kinds and derives the flags from that kind. It draws register numbers from a narrow range so that matches, register-0 cases and simultaneous matches in both older stages occur often. All inputs change on the falling edge.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'd0,
    SEL_EXM = 2'd1,
    SEL_MWB = 2'd2
  } byp_sel_e;

  localparam int unsigned NUM_CONSUMERS = 3;
  localparam int unsigned CONS_A  = 0;
  localparam int unsigned CONS_B  = 1;
  localparam int unsigned CONS_ST = 2;
endpackage

// File: rtl/hz_producer_qual.sv
module hz_producer_qual #(
  parameter int unsigned AW         = 5,
  parameter bit          BLOCK_LOAD = 1'b0
) (
  input  logic          nop,
  input  logic          wen,
  input  logic          rd_mem,
  input  logic [AW-1:0] dst,
  output logic          ok
);
  function automatic logic writes_real_reg(input logic n, input logic w,
                                           input logic [AW-1:0] d);
    return !n && w && (d != '0);
  endfunction

  logic base_ok;
  assign base_ok = writes_real_reg(nop, wen, dst);

  generate
    if (BLOCK_LOAD) begin : g_block
      assign ok = base_ok && !rd_mem;
    end else begin : g_pass
      logic unused_rd;
      assign unused_rd = rd_mem;
      assign ok = base_ok;
    end
  endgenerate
endmodule

// File: rtl/hz_src_pick.sv
module hz_src_pick
  import hz_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic          en,
  input  logic [AW-1:0] src,
  input  logic          exm_ok,
  input  logic [AW-1:0] exm_dst,
  input  logic          mwb_ok,
  input  logic [AW-1:0] mwb_dst,
  output logic          hit_exm,
  output logic          hit_mwb,
  output byp_sel_e      sel
);
  assign hit_exm = en && exm_ok && (exm_dst == src);
  assign hit_mwb = en && mwb_ok && (mwb_dst == src);

  always_comb begin
    if (hit_exm)      sel = SEL_EXM;
    else if (hit_mwb) sel = SEL_MWB;
    else              sel = SEL_RF;
  end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int unsigned AW = 5
) (
  input  logic          id_nop,
  input  logic [AW-1:0] id_rs,
  input  logic [AW-1:0] id_rt,
  input  logic          id_uses_rt,
  input  logic          ex_nop,
  input  logic          ex_rd_mem,
  input  logic          ex_wen,
  input  logic [AW-1:0] ex_dst,
  output logic          load_in_ex,
  output logic          rs_dep,
  output logic          rt_dep,
  output logic          stall
);
  assign load_in_ex = !ex_nop && ex_rd_mem && ex_wen && (ex_dst != '0);
  assign rs_dep     = !id_nop && (id_rs == ex_dst);
  assign rt_dep     = !id_nop && id_uses_rt && (id_rt == ex_dst);
  assign stall      = load_in_ex && (rs_dep || rt_dep);
endmodule

// File: rtl/hz_unit.sv
module hz_unit
  import hz_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          id_nop,
  input  logic [AW-1:0] id_rs,
  input  logic [AW-1:0] id_rt,
  input  logic          id_uses_rt,
  input  logic          ex_nop,
  input  logic [AW-1:0] ex_rs,
  input  logic [AW-1:0] ex_rt,
  input  logic [AW-1:0] ex_dst,
  input  logic          ex_wen,
  input  logic          ex_is_itype,
  input  logic          ex_rd_mem,
  input  logic          ex_wr_mem,
  input  logic          mem_nop,
  input  logic [AW-1:0] mem_dst,
  input  logic          mem_wen,
  input  logic          mem_rd_mem,
  input  logic          wb_nop,
  input  logic [AW-1:0] wb_dst,
  input  logic          wb_wen,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic [1:0]    sel_st,
  output logic          stall
);
  localparam int unsigned NC = NUM_CONSUMERS;

  // Producer qualification: the EX/MEM copy refuses loads, MEM/WB accepts them.
  logic exm_ok, mwb_ok;

  hz_producer_qual #(.AW(AW), .BLOCK_LOAD(1'b1)) u_q_exm (
    .nop(mem_nop), .wen(mem_wen), .rd_mem(mem_rd_mem), .dst(mem_dst), .ok(exm_ok)
  );

  hz_producer_qual #(.AW(AW), .BLOCK_LOAD(1'b0)) u_q_mwb (
    .nop(wb_nop), .wen(wb_wen), .rd_mem(1'b0), .dst(wb_dst), .ok(mwb_ok)
  );

  // Consumers in execute: operand A, operand B, store data.
  logic [AW-1:0] c_src [NC];
  logic          c_en  [NC];
  logic          c_hit_exm [NC];
  logic          c_hit_mwb [NC];
  byp_sel_e      c_sel [NC];

  assign c_src[CONS_A]  = ex_rs;
  assign c_src[CONS_B]  = ex_rt;
  assign c_src[CONS_ST] = ex_rt;
  assign c_en[CONS_A]   = !ex_nop;
  assign c_en[CONS_B]   = !ex_nop && !ex_is_itype;
  assign c_en[CONS_ST]  = !ex_nop && ex_wr_mem;

  generate
    for (genvar g = 0; g < NC; g++) begin : g_cons
      hz_src_pick #(.AW(AW)) u_pick (
        .en(c_en[g]), .src(c_src[g]),
        .exm_ok(exm_ok), .exm_dst(mem_dst),
        .mwb_ok(mwb_ok), .mwb_dst(wb_dst),
        .hit_exm(c_hit_exm[g]), .hit_mwb(c_hit_mwb[g]),
        .sel(c_sel[g])
      );
    end
  endgenerate

  assign sel_a  = c_sel[CONS_A];
  assign sel_b  = c_sel[CONS_B];
  assign sel_st = c_sel[CONS_ST];

  // Load-use interlock
  logic load_in_ex, rs_dep, rt_dep;

  hz_load_use #(.AW(AW)) u_lu (
    .id_nop(id_nop), .id_rs(id_rs), .id_rt(id_rt), .id_uses_rt(id_uses_rt),
    .ex_nop(ex_nop), .ex_rd_mem(ex_rd_mem), .ex_wen(ex_wen), .ex_dst(ex_dst),
    .load_in_ex(load_in_ex), .rs_dep(rs_dep), .rt_dep(rt_dep), .stall(stall)
  );

  // Checks
  a_r1_exm_source_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a == 2'd1) |-> (!mem_nop && mem_wen && mem_dst != '0 && mem_dst == ex_rs));

  a_r2_exm_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (c_hit_exm[CONS_A] && c_hit_mwb[CONS_A]) |-> (sel_a == 2'd1));

  a_r3_mwb_source_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a == 2'd2) |-> (!wb_nop && wb_wen && wb_dst != '0 && wb_dst == ex_rs));

  a_r4_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a != 2'd3) && (sel_b != 2'd3) && (sel_st != 2'd3));

  a_r5_imm_no_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    ex_is_itype |-> (sel_b == 2'd0));

  a_r6_store_only: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_wr_mem |-> (sel_st == 2'd0));

  a_r7_bubble_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ex_nop |-> (sel_a == 2'd0 && sel_b == 2'd0 && sel_st == 2'd0 && !stall));

  a_r8_stall_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (ex_rd_mem && !ex_nop && !id_nop && ex_dst != '0));

  a_r9_rt_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !id_uses_rt) |-> (id_rs == ex_dst));

  a_r10_no_load_from_exm: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_mem |-> (sel_a != 2'd1 && sel_b != 2'd1 && sel_st != 2'd1));
endmodule

// File: tb/hz_unit_tb.sv
`timescale 1ns/1ps
module hz_unit_tb;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic id_nop, id_uses_rt, ex_nop, ex_wen, ex_is_itype, ex_rd_mem, ex_wr_mem;
  logic mem_nop, mem_wen, mem_rd_mem, wb_nop, wb_wen;
  logic [AW-1:0] id_rs, id_rt, ex_rs, ex_rt, ex_dst, mem_dst, wb_dst;
  logic [1:0] sel_a, sel_b, sel_st;
  logic stall;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  hz_unit #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .id_nop(id_nop), .id_rs(id_rs), .id_rt(id_rt), .id_uses_rt(id_uses_rt),
    .ex_nop(ex_nop), .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_dst(ex_dst),
    .ex_wen(ex_wen), .ex_is_itype(ex_is_itype), .ex_rd_mem(ex_rd_mem),
    .ex_wr_mem(ex_wr_mem),
    .mem_nop(mem_nop), .mem_dst(mem_dst), .mem_wen(mem_wen), .mem_rd_mem(mem_rd_mem),
    .wb_nop(wb_nop), .wb_dst(wb_dst), .wb_wen(wb_wen),
    .sel_a(sel_a), .sel_b(sel_b), .sel_st(sel_st), .stall(stall)
  );

  // Kinds: 0 addu, 1 subu, 2 lw, 3 sw
  task automatic put_id(input bit nop, input int k, input int rs, input int rt);
    id_nop = nop; id_rs = rs[AW-1:0]; id_rt = rt[AW-1:0];
    id_uses_rt = (k != 2);
  endtask

  task automatic put_ex(input bit nop, input int k, input int rs, input int rt, input int d);
    ex_nop = nop; ex_rs = rs[AW-1:0]; ex_rt = rt[AW-1:0]; ex_dst = d[AW-1:0];
    ex_is_itype = (k >= 2); ex_wen = (k != 3);
    ex_rd_mem = (k == 2); ex_wr_mem = (k == 3);
  endtask

  task automatic put_mem(input bit nop, input int k, input int d);
    mem_nop = nop; mem_dst = d[AW-1:0]; mem_wen = (k != 3); mem_rd_mem = (k == 2);
  endtask

  task automatic put_wb(input bit nop, input int k, input int d);
    wb_nop = nop; wb_dst = d[AW-1:0]; wb_wen = (k != 3);
  endtask

  task automatic all_idle();
    put_id(1, 0, 0, 0); put_ex(1, 0, 0, 0, 0); put_mem(1, 0, 0); put_wb(1, 0, 0);
  endtask

  // Behavioural reference
  function automatic int ref_sel(input bit en, input int src);
    int s = 0;
    if (en) begin
      if (!mem_nop && mem_wen && !mem_rd_mem && int'(mem_dst) != 0 && int'(mem_dst) == src) s = 1;
      else if (!wb_nop && wb_wen && int'(wb_dst) != 0 && int'(wb_dst) == src) s = 2;
    end
    return s;
  endfunction

  function automatic int ref_stall();
    int hit = 0;
    if (!ex_nop && !id_nop && ex_rd_mem && ex_wen && int'(ex_dst) != 0) begin
      if (int'(id_rs) == int'(ex_dst)) hit = 1;
      if (id_uses_rt && int'(id_rt) == int'(ex_dst)) hit = 1;
    end
    return hit;
  endfunction

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: got=%0d expected=%0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, "sel_a",  int'(sel_a),  ref_sel(!ex_nop, int'(ex_rs)));
    chk(tag, "sel_b",  int'(sel_b),  ref_sel(!ex_nop && !ex_is_itype, int'(ex_rt)));
    chk(tag, "sel_st", int'(sel_st), ref_sel(!ex_nop && ex_wr_mem, int'(ex_rt)));
    chk(tag, "stall",  int'(stall),  ref_stall());
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    all_idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R7 reset / all bubbles
    #1; chk("R7", "idle sel_a", int'(sel_a), 0); chk("R7", "idle stall", int'(stall), 0);

    // R1 EX/MEM bypass on rs
    step(); all_idle(); put_ex(0, 0, 3, 4, 7); put_mem(0, 1, 3);
    #1; chk("R1", "sel_a", int'(sel_a), 1); chk_all("R1");

    // R2 both match
    step(); all_idle(); put_ex(0, 1, 3, 4, 7); put_mem(0, 0, 3); put_wb(0, 2, 3);
    #1; chk("R2", "sel_a", int'(sel_a), 1);

    // R3 MEM/WB only
    step(); all_idle(); put_ex(0, 0, 3, 4, 7); put_wb(0, 0, 3);
    #1; chk("R3", "sel_a", int'(sel_a), 2);

    // R4 gating cases
    step(); all_idle(); put_ex(0, 0, 0, 0, 7); put_mem(0, 0, 0); put_wb(0, 0, 0);
    #1; chk("R4", "dst0 sel_a", int'(sel_a), 0); chk("R4", "dst0 sel_b", int'(sel_b), 0);
    step(); all_idle(); put_ex(0, 0, 3, 3, 7); put_mem(1, 0, 3); put_wb(0, 3, 3);
    #1; chk("R4", "nop/wen0 sel_a", int'(sel_a), 0); chk("R4", "nop/wen0 sel_b", int'(sel_b), 0);
    step(); all_idle(); put_ex(0, 2, 1, 2, 0); put_id(0, 0, 0, 0);
    #1; chk("R4", "load to r0 stall", int'(stall), 0);

    // R5 operand B
    step(); all_idle(); put_ex(0, 2, 1, 5, 5); put_mem(0, 0, 5);
    #1; chk("R5", "itype sel_b", int'(sel_b), 0);
    step(); all_idle(); put_ex(0, 1, 1, 5, 6); put_wb(0, 2, 5);
    #1; chk("R5", "rtype sel_b", int'(sel_b), 2);

    // R6 store data
    step(); all_idle(); put_ex(0, 3, 1, 5, 0); put_mem(0, 0, 5);
    #1; chk("R6", "sw sel_st", int'(sel_st), 1); chk("R6", "sw sel_b", int'(sel_b), 0);
    step(); all_idle(); put_ex(0, 0, 1, 5, 9); put_mem(0, 0, 5);
    #1; chk("R6", "addu sel_st", int'(sel_st), 0);

    // R7 execute bubble
    step(); all_idle(); put_ex(1, 2, 3, 3, 4); put_mem(0, 0, 3); put_wb(0, 0, 3); put_id(0, 0, 4, 4);
    #1; chk("R7", "sel_a", int'(sel_a), 0); chk("R7", "sel_st", int'(sel_st), 0);
    chk("R7", "stall", int'(stall), 0);

    // R8 load-use on rs
    step(); all_idle(); put_ex(0, 2, 1, 2, 5); put_id(0, 2, 5, 9);
    #1; chk("R8", "stall", int'(stall), 1);
    step(); all_idle(); put_ex(0, 2, 1, 2, 5); put_id(1, 0, 5, 5);
    #1; chk("R8", "id nop stall", int'(stall), 0);

    // R9 rt read flag
    step(); all_idle(); put_ex(0, 2, 1, 2, 6); put_id(0, 2, 1, 6);
    #1; chk("R9", "lw rt stall", int'(stall), 0);
    step(); all_idle(); put_ex(0, 2, 1, 2, 6); put_id(0, 3, 1, 6);
    #1; chk("R9", "sw rt stall", int'(stall), 1);

    // R10 load in EX/MEM
    step(); all_idle(); put_ex(0, 0, 4, 4, 8); put_mem(0, 2, 4); put_wb(0, 0, 4);
    #1; chk("R10", "fallback sel_a", int'(sel_a), 2);
    step(); all_idle(); put_ex(0, 0, 4, 4, 8); put_mem(0, 2, 4);
    #1; chk("R10", "no source sel_a", int'(sel_a), 0);

    // Random streams, compared with the reference every cycle
    for (int i = 0; i < 3000; i++) begin
      step();
      put_id($urandom_range(0, 4) == 0, $urandom_range(0, 3),
             $urandom_range(0, 3), $urandom_range(0, 3));
      put_ex($urandom_range(0, 4) == 0, $urandom_range(0, 3),
             $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3));
      put_mem($urandom_range(0, 3) == 0, $urandom_range(0, 3), $urandom_range(0, 3));
      put_wb($urandom_range(0, 3) == 0, $urandom_range(0, 3), $urandom_range(0, 3));
      #1; chk_all("R1 R5 R6 R8 random");
    end

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      checks++; bad++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule